// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block runs read and write accesses to an asynchronous 16-bit external memory device. Each access is built from three programmable phases: an address/select setup phase, a strobe phase in which output-enable (reads) or write-enable (writes) is low, and a hold phase. Reads and writes have separate lengths for all three phases. After every access the controller enforces a programmable idle gap so the next access cannot collide with the previous bus owner. A select-strobe option narrows chip-enable so that it is low only while the strobe is low.

The memory can stretch the strobe phase by asserting an active-high wait input. The controller resynchronizes and deglitches that input. It extends the strobe only when the filtered wait is seen early enough and is still asserted when the strobe would end. A programmable maximum-wait count caps the stretch. When the cap is reached with wait still high, the access is closed and flagged as timed out.

On the host side there is a ready/request handshake with address, write data and write flag, plus a one-cycle done pulse carrying the read data and the timeout flag. Configuration inputs are encoded as length minus one and are sampled live, so they must be held steady while an access is in flight.

Top module: `async_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are: `host_ready`=1, `mem_ce_n`=`mem_oe_n`=`mem_we_n`=1, `mem_dq_oe`=0 and `host_done`=0.
- R2: A read without extension takes exactly (rd_setup+1)+(rd_strobe+1)+(rd_hold+1) cycles. These are counted from the accepting clock edge to the cycle in which `host_done` is high. `mem_oe_n` is low for exactly the strobe count and never together with `mem_we_n`.
- R3: A write uses the write phase lengths in the same way, with `mem_we_n` low for the strobe count. `mem_dq_oe` is high for every cycle from the start of setup to the end of hold, with `mem_dq_o` equal to the accepted write data. It is never high while `mem_oe_n` is low.
- R4: With `cfg_sel_strobe`=0, `mem_ce_n` falls in the first setup cycle and stays low through the last hold cycle. The strobe falls setup-count cycles after chip-enable.
- R5: With `cfg_sel_strobe`=1, `mem_ce_n` is low exactly in the cycles in which the strobe is low.
- R6: Read data is the value on `mem_dq_i` in the last strobe cycle. It is presented on `host_rdata` from the done cycle onward.
- R7: `host_ready` returns exactly (cfg_turn+1) cycles after the done cycle, and `host_done` is never high while `host_ready` is high.
- R8: `mem_wait` reaches the state machine 4 cycles after it changes at the pin. The strobe is extended only if the filtered wait is high in a setup or strobe cycle with at least 4 cycles left before hold, and is still high in the last strobe cycle. Otherwise the access keeps its plain length.
- R9: While extended, the strobe continues until the filtered wait is seen low. If `mem_wait` drops in cycle j after acceptance, done comes in cycle j+5+hold count.
- R10: Extension is capped at 16*(cfg_max_wait+1) cycles. An access that reaches the cap with wait still high ends normally and raises `host_timeout` together with `host_done`.
- R11: A change of `mem_wait` lasting one cycle is ignored. A change lasting two cycles is acted on.
- R12: With `cfg_ext_wait`=0, `mem_wait` has no effect on access length.
- R13: `host_req` is ignored while `host_ready` is low: the memory address does not change and exactly one single-cycle done pulse is produced per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one cycle is the timing unit |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when `host_ready` is high |
| host_write | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | AW | Access address |
| host_wdata | input | DW | Write data |
| host_ready | output | 1 | Controller idle, request will be taken |
| host_done | output | 1 | One-cycle end-of-access pulse |
| host_timeout | output | 1 | High with `host_done` when the wait cap was hit |
| host_rdata | output | DW | Read data captured at end of strobe |
| cfg_turn | input | 2 | Idle gap minus one (1..4 cycles) |
| cfg_rd_setup | input | 4 | Read setup minus one (1..16) |
| cfg_rd_strobe | input | 6 | Read strobe minus one (1..64) |
| cfg_rd_hold | input | 3 | Read hold minus one (1..8) |
| cfg_wr_setup | input | 4 | Write setup minus one (1..16) |
| cfg_wr_strobe | input | 6 | Write strobe minus one (1..64) |
| cfg_wr_hold | input | 3 | Write hold minus one (1..8) |
| cfg_sel_strobe | input | 1 | Chip-enable framed by the strobe only |
| cfg_ext_wait | input | 1 | Allow wait-driven strobe extension |
| cfg_max_wait | input | 8 | Wait cap minus one, in units of 16 cycles |
| mem_wait | input | 1 | Active-high wait from the memory |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | DW | Data received from the memory |

## Verification
The bench builds the controller with its default 16-bit address and data and two synchronizer stages. It keeps the phase lengths small, so one sweep covers every combination of a few setup, strobe, hold and turnaround lengths with both chip-enable framings and both access directions. A smallest wait cap of 16 cycles puts the timeout within a few dozen cycles. With a fixed 2+6 cycle read front, the window edge becomes a single cycle of wait timing, so the extend and no-extend cases sit one cycle apart. The same front exposes the one-cycle and two-cycle release glitches at known cycle numbers.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int TURN_W      = 2;
    localparam int SETUP_W     = 4;
    localparam int STROBE_W    = 6;
    localparam int HOLD_W      = 3;
    localparam int MAXW_W      = 8;
    localparam int EXT_SHIFT   = 4;
    localparam int WAIT_WINDOW = 4;

    localparam int CNT_W  = STROBE_W;
    localparam int TILL_W = STROBE_W + 2;
    localparam int EXT_W  = MAXW_W + 1 + EXT_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_EXTEND,
        ST_HOLD,
        ST_TURN
    } amc_state_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } amc_phase_t;

    // cycles of extension allowed before timeout
    function automatic logic [EXT_W-1:0] ext_limit(input logic [MAXW_W-1:0] m);
        logic [EXT_W-1:0] units;
        units = EXT_W'(m) + EXT_W'(1);
        return units << EXT_SHIFT;
    endfunction

    // number of setup plus strobe cycles (fields are encoded minus one)
    function automatic logic [TILL_W-1:0] span_to_hold(input amc_phase_t p);
        return TILL_W'(p.setup) + TILL_W'(p.strobe) + TILL_W'(2);
    endfunction

    function automatic logic in_frame(input amc_state_e s);
        return (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_EXTEND) || (s == ST_HOLD);
    endfunction

    function automatic logic in_strobe(input amc_state_e s);
        return (s == ST_STROBE) || (s == ST_EXTEND);
    endfunction

endpackage

// File: rtl/amc_wait_filter.sv
module amc_wait_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_raw,
    output logic wait_clean
);
    // chain[SYNC_STAGES-1] is the synchronized value, chain[SYNC_STAGES] one cycle older
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain      <= '0;
            wait_clean <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], wait_raw};
            // accept a new level only once two consecutive samples agree
            if (chain[SYNC_STAGES] == chain[SYNC_STAGES-1]) begin
                wait_clean <= chain[SYNC_STAGES-1];
            end
        end
    end

endmodule

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  amc_phase_t        rd_ph,
    input  amc_phase_t        wr_ph,
    input  logic [TURN_W-1:0] turn,
    input  logic              ext_en,
    input  logic [MAXW_W-1:0] max_wait,
    input  logic              wait_clean,
    output amc_state_e        state,
    output logic              cur_write,
    output logic              accept,
    output logic              cap_en,
    output logic              done,
    output logic              timeout
);
    logic [CNT_W-1:0]  cnt;
    logic [TILL_W-1:0] till;
    logic [EXT_W-1:0]  ecnt;
    logic              seen;
    logic              to_q;
    logic              done_q;

    amc_phase_t        ph_new;
    amc_phase_t        ph_cur;
    logic [EXT_W-1:0]  limit;
    logic              window_hit;
    logic              strobe_end;
    logic              ext_go;
    logic              ext_exit;
    logic              limit_hit;

    always_comb begin
        ph_new     = host_write ? wr_ph : rd_ph;
        ph_cur     = cur_write  ? wr_ph : rd_ph;
        limit      = ext_limit(max_wait);
        accept     = (state == ST_IDLE) && host_req;
        window_hit = ext_en && wait_clean
                     && ((state == ST_SETUP) || (state == ST_STROBE))
                     && (till >= TILL_W'(WAIT_WINDOW));
        strobe_end = (state == ST_STROBE) && (cnt == '0);
        ext_go     = strobe_end && ext_en && seen && wait_clean;
        limit_hit  = (ecnt == limit - EXT_W'(1));
        ext_exit   = (state == ST_EXTEND) && (!wait_clean || limit_hit);
        cap_en     = (strobe_end && !ext_go) || ext_exit;
        done       = done_q;
        timeout    = done_q && to_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            till      <= '0;
            ecnt      <= '0;
            seen      <= 1'b0;
            to_q      <= 1'b0;
            done_q    <= 1'b0;
            cur_write <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (((state == ST_SETUP) || (state == ST_STROBE)) && (till != '0)) begin
                till <= till - TILL_W'(1);
            end
            if (window_hit) begin
                seen <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_write <= host_write;
                        cnt       <= CNT_W'(ph_new.setup);
                        till      <= span_to_hold(ph_new);
                        seen      <= 1'b0;
                        to_q      <= 1'b0;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_W'(ph_cur.strobe);
                        state <= ST_STROBE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    if (ext_go) begin
                        ecnt  <= '0;
                        state <= ST_EXTEND;
                    end else if (strobe_end) begin
                        cnt   <= CNT_W'(ph_cur.hold);
                        state <= ST_HOLD;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_EXTEND: begin
                    if (ext_exit) begin
                        to_q  <= wait_clean;
                        cnt   <= CNT_W'(ph_cur.hold);
                        state <= ST_HOLD;
                    end else begin
                        ecnt <= ecnt + EXT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        done_q <= 1'b1;
                        cnt    <= CNT_W'(turn);
                        state  <= ST_TURN;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_TURN: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amc_pins.sv
module amc_pins
    import amc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  amc_state_e    state,
    input  logic          cur_write,
    input  logic          sel_strobe,
    input  logic          cap_en,
    input  logic [DW-1:0] mem_dq_i,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          frame;
    logic          strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (cap_en && !cur_write) begin
                rdata_q <= mem_dq_i;
            end
        end
    end

    always_comb begin
        frame     = in_frame(state);
        strobe    = in_strobe(state);
        mem_ce_n  = sel_strobe ? !strobe : !frame;
        mem_oe_n  = !(strobe && !cur_write);
        mem_we_n  = !(strobe && cur_write);
        mem_dq_oe = frame && cur_write;
        mem_dq_o  = wdata_q;
        mem_addr  = addr_q;
        rdata     = rdata_q;
    end

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import amc_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_write,
    input  logic [AW-1:0]       host_addr,
    input  logic [DW-1:0]       host_wdata,
    output logic                host_ready,
    output logic                host_done,
    output logic                host_timeout,
    output logic [DW-1:0]       host_rdata,
    input  logic [TURN_W-1:0]   cfg_turn,
    input  logic [SETUP_W-1:0]  cfg_rd_setup,
    input  logic [STROBE_W-1:0] cfg_rd_strobe,
    input  logic [HOLD_W-1:0]   cfg_rd_hold,
    input  logic [SETUP_W-1:0]  cfg_wr_setup,
    input  logic [STROBE_W-1:0] cfg_wr_strobe,
    input  logic [HOLD_W-1:0]   cfg_wr_hold,
    input  logic                cfg_sel_strobe,
    input  logic                cfg_ext_wait,
    input  logic [MAXW_W-1:0]   cfg_max_wait,
    input  logic                mem_wait,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_dq_i
);
    amc_phase_t rd_ph;
    amc_phase_t wr_ph;
    amc_state_e state;
    logic       wait_clean;
    logic       cur_write;
    logic       accept;
    logic       cap_en;

    always_comb begin
        rd_ph      = '{setup: cfg_rd_setup, strobe: cfg_rd_strobe, hold: cfg_rd_hold};
        wr_ph      = '{setup: cfg_wr_setup, strobe: cfg_wr_strobe, hold: cfg_wr_hold};
        host_ready = (state == ST_IDLE);
    end

    amc_wait_filter #(.SYNC_STAGES(SYNC_STAGES)) u_wait (
        .clk        (clk),
        .rst        (rst),
        .wait_raw   (mem_wait),
        .wait_clean (wait_clean)
    );

    amc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_write (host_write),
        .rd_ph      (rd_ph),
        .wr_ph      (wr_ph),
        .turn       (cfg_turn),
        .ext_en     (cfg_ext_wait),
        .max_wait   (cfg_max_wait),
        .wait_clean (wait_clean),
        .state      (state),
        .cur_write  (cur_write),
        .accept     (accept),
        .cap_en     (cap_en),
        .done       (host_done),
        .timeout    (host_timeout)
    );

    amc_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .state      (state),
        .cur_write  (cur_write),
        .sel_strobe (cfg_sel_strobe),
        .cap_en     (cap_en),
        .mem_dq_i   (mem_dq_i),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .rdata      (host_rdata)
    );

endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          host_ready,
    input logic          host_done,
    input logic          cfg_sel_strobe,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R2

    AST_NO_DRIVE_UNDER_OE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R3

    AST_STROBE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n); // R4

    AST_SEL_STROBE_FRAME: assert property (@(posedge clk) disable iff (rst)
        cfg_sel_strobe |-> (mem_ce_n == (mem_oe_n && mem_we_n))); // R5

    AST_DONE_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        host_done |-> !host_ready); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done); // R13

    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !host_ready |=> $stable(mem_addr)); // R13

endmodule

bind async_mem_ctrl amc_checker #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_ready     (host_ready),
    .host_done      (host_done),
    .cfg_sel_strobe (cfg_sel_strobe),
    .mem_ce_n       (mem_ce_n),
    .mem_oe_n       (mem_oe_n),
    .mem_we_n       (mem_we_n),
    .mem_dq_oe      (mem_dq_oe),
    .mem_addr       (mem_addr)
);

// File: tb/async_mem_ctrl_tb.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready;
    logic          host_done;
    logic          host_timeout;
    logic [DW-1:0] host_rdata;
    logic [1:0]    cfg_turn = '0;
    logic [3:0]    cfg_rd_setup = '0;
    logic [5:0]    cfg_rd_strobe = '0;
    logic [2:0]    cfg_rd_hold = '0;
    logic [3:0]    cfg_wr_setup = '0;
    logic [5:0]    cfg_wr_strobe = '0;
    logic [2:0]    cfg_wr_hold = '0;
    logic          cfg_sel_strobe = 1'b0;
    logic          cfg_ext_wait = 1'b0;
    logic [7:0]    cfg_max_wait = '0;
    logic          mem_wait = 1'b0;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i;

    int total = 0;
    int bad   = 0;
    int RS, RT, RH, WS, WT, WH, TA, SEL, EXT, MW;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
        return (a * 16'd3) ^ 16'h5A3C;
    endfunction

    assign mem_dq_i = mem_oe_n ? 16'h0000 : rd_model(mem_addr);

    async_mem_ctrl u_dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_done(host_done),
        .host_timeout(host_timeout), .host_rdata(host_rdata),
        .cfg_turn(cfg_turn), .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe),
        .cfg_rd_hold(cfg_rd_hold), .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe),
        .cfg_wr_hold(cfg_wr_hold), .cfg_sel_strobe(cfg_sel_strobe), .cfg_ext_wait(cfg_ext_wait),
        .cfg_max_wait(cfg_max_wait), .mem_wait(mem_wait),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic apply_cfg();
        cfg_rd_setup   = 4'(RS - 1);
        cfg_rd_strobe  = 6'(RT - 1);
        cfg_rd_hold    = 3'(RH - 1);
        cfg_wr_setup   = 4'(WS - 1);
        cfg_wr_strobe  = 6'(WT - 1);
        cfg_wr_hold    = 3'(WH - 1);
        cfg_turn       = 2'(TA - 1);
        cfg_sel_strobe = SEL[0];
        cfg_ext_wait   = EXT[0];
        cfg_max_wait   = 8'(MW);
    endtask

    function automatic logic wait_lvl(input int j, input int on, input int off, input int g0, input int g1);
        return (j >= on) && (j < off) && !((j >= g0) && (j < g1));
    endfunction

    // exp_total < 0 means the plain phase sum
    task automatic run_access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input int on, input int off, input int g0, input int g1,
                              input int exp_total_in, input bit exp_to, input string rq,
                              input bit busy_req);
        int s, t, h, exp_total, slen;
        int done_idx, done_cnt, ready_idx, ce_cnt, ce_first, st_cnt, st_first;
        int oe_cnt, dq_cnt, dq_bad, addr_bad, to_seen, ce_idle_bad;
        logic [DW-1:0] rd_got;
        s = w ? WS : RS;
        t = w ? WT : RT;
        h = w ? WH : RH;
        exp_total = (exp_total_in < 0) ? (s + t + h) : exp_total_in;
        slen = exp_total - s - h;
        done_idx = -1; done_cnt = 0; ready_idx = -1; ce_cnt = 0; ce_first = -1;
        st_cnt = 0; st_first = -1; oe_cnt = 0; dq_cnt = 0; dq_bad = 0; addr_bad = 0;
        to_seen = 0; ce_idle_bad = 0; rd_got = '0;

        @(negedge clk);
        host_req   = 1'b1;
        host_write = w;
        host_addr  = a;
        host_wdata = d;
        mem_wait   = wait_lvl(-1, on, off, g0, g1);
        @(posedge clk);
        for (int j = 0; j < 6000; j++) begin
            @(negedge clk);
            if (host_done) begin
                done_cnt++;
                if (done_idx < 0) begin
                    done_idx = j;
                    to_seen  = host_timeout;
                    rd_got   = host_rdata;
                end
            end
            if (done_idx < 0 || j == done_idx) begin
                if (!mem_ce_n) begin ce_cnt++; if (ce_first < 0) ce_first = j; end
                if (!mem_oe_n || !mem_we_n) begin st_cnt++; if (st_first < 0) st_first = j; end
                if (!mem_oe_n) oe_cnt++;
                if (mem_dq_oe) begin dq_cnt++; if (mem_dq_o != d) dq_bad++; end
                if (mem_addr != a) addr_bad++;
            end
            if (done_idx >= 0 && host_ready) begin
                ready_idx = j;
                break;
            end
            host_req = busy_req && (j >= 1) && (j < 4);
            if (busy_req) host_addr = ~a;
            mem_wait = wait_lvl(j, on, off, g0, g1);
        end
        host_req = 1'b0;
        mem_wait = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!mem_ce_n || host_done) ce_idle_bad++;
        end

        chk(done_idx == exp_total, rq, "done cycle", done_idx, exp_total);
        chk(to_seen == int'(exp_to), "R10", "timeout flag", to_seen, int'(exp_to));
        chk(ready_idx == exp_total + TA, "R7", "ready return", ready_idx, exp_total + TA);
        chk(st_cnt == slen, rq, "strobe cycles", st_cnt, slen);
        chk(st_first == s, "R4", "strobe start", st_first, s);
        if (SEL != 0) begin
            chk(ce_cnt == slen, "R5", "ce cycles", ce_cnt, slen);
            chk(ce_first == s, "R5", "ce start", ce_first, s);
        end else begin
            chk(ce_cnt == exp_total, "R4", "ce cycles", ce_cnt, exp_total);
            chk(ce_first == 0, "R4", "ce start", ce_first, 0);
        end
        if (w) begin
            chk(oe_cnt == 0, "R3", "oe during write", oe_cnt, 0);
            chk(dq_cnt == exp_total, "R3", "dq drive cycles", dq_cnt, exp_total);
            chk(dq_bad == 0, "R3", "dq value errors", dq_bad, 0);
        end else begin
            chk(dq_cnt == 0, "R2", "dq drive in read", dq_cnt, 0);
            chk(rd_got == rd_model(a), "R6", "read data", int'(rd_got), int'(rd_model(a)));
        end
        chk(addr_bad == 0, "R13", "address changes", addr_bad, 0);
        chk(done_cnt == 1, "R13", "done pulses", done_cnt, 1);
        chk(ce_idle_bad == 0, "R13", "idle after access", ce_idle_bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        RS = 1; RT = 1; RH = 1; WS = 1; WT = 1; WH = 1; TA = 1; SEL = 0; EXT = 0; MW = 0;
        apply_cfg();
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done,
            "R1", "outputs in reset", 0, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done,
            "R1", "outputs after reset", 0, 1);

        // R2 R3 R4 R5 R7: sweep of small phase lengths, both framings, both directions
        for (int si = 1; si <= 3; si++)
            for (int ti = 0; ti < 3; ti++)
                for (int hi = 0; hi < 2; hi++)
                    for (int ai = 0; ai < 2; ai++)
                        for (int sel = 0; sel < 2; sel++)
                            for (int w = 0; w < 2; w++) begin
                                RS = si; RT = (ti == 0) ? 1 : (ti == 1 ? 2 : 5); RH = (hi == 0) ? 1 : 3;
                                WS = 4 - si; WT = RT + 1; WH = 4 - RH;
                                TA = (ai == 0) ? 1 : 4; SEL = sel; EXT = 1; MW = 0;
                                apply_cfg();
                                run_access(w[0], 16'(si * 97 + ti * 13 + w), 16'(16'hA500 + si * 7 + hi),
                                           100, 100, 0, 0, -1, 1'b0, (w != 0) ? "R3" : "R2", 1'b0);
                            end

        // fixed front for wait tests: setup 2, strobe 6, hold 2
        RS = 2; RT = 6; RH = 2; WS = 2; WT = 6; WH = 2; TA = 1; SEL = 0; EXT = 1; MW = 0;
        apply_cfg();
        // R8 R9: wait seen at window edge, released in cycle 12 -> done at 12+5+2
        run_access(1'b0, 16'h0123, 16'h0, 0, 12, 0, 0, 19, 1'b0, "R9", 1'b0);
        // R8: wait one cycle later misses the window -> plain length
        run_access(1'b0, 16'h0456, 16'h0, 1, 30, 0, 0, 10, 1'b0, "R8", 1'b0);
        // R9: write extended the same way
        run_access(1'b1, 16'h0789, 16'hBEEF, 0, 12, 0, 0, 19, 1'b0, "R9", 1'b0);
        // R10: wait held, cap 16 cycles
        run_access(1'b0, 16'h0ABC, 16'h0, -1, 1000, 0, 0, 26, 1'b1, "R10", 1'b0);
        // R10: cap 32 cycles
        MW = 1; apply_cfg();
        run_access(1'b0, 16'h0DEF, 16'h0, -1, 1000, 0, 0, 42, 1'b1, "R10", 1'b0);
        // R11: one-cycle low glitch ignored, release in cycle 40
        MW = 3; apply_cfg();
        run_access(1'b0, 16'h1111, 16'h0, -1, 40, 15, 16, 47, 1'b0, "R11", 1'b0);
        // R11: two-cycle low ends extension
        run_access(1'b0, 16'h2222, 16'h0, -1, 40, 15, 17, 22, 1'b0, "R11", 1'b0);
        // R12: extension disabled, wait held
        EXT = 0; apply_cfg();
        run_access(1'b0, 16'h3333, 16'h0, -1, 1000, 0, 0, 10, 1'b0, "R12", 1'b0);
        // R13: requests while busy are ignored
        EXT = 1; apply_cfg();
        run_access(1'b0, 16'h4444, 16'h0, 100, 100, 0, 0, -1, 1'b0, "R13", 1'b1);
        SEL = 1; apply_cfg();
        run_access(1'b1, 16'h5555, 16'h1234, 100, 100, 0, 0, -1, 1'b0, "R13", 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule